// File: doc/BRIEF.md
# Dual-Channel Load-Switch Diagnostic Controller

This block is the digital control and diagnosis core of a two-channel high-side load switch. Each channel receives a logic command and four synchronous comparator flags from the analog side:
- overtemperature
- current limiting active
- on-state undercurrent
- output high while off

Two flags are shared by both channels: supply undervoltage and supply overvoltage. For each channel the block drives a gate-enable output to the power stage and an active-low status output meant to drive an open-drain diagnostic line.

The core decides the gate and status for every fault condition, taking the command level into account. It filters each fault report through its own delay, and it restarts a channel on its own once the overtemperature flag drops. The delays are counted in ticks of a clock-enable input, and each delay length is a parameter. The default values assume one tick per microsecond: 20 ticks for overtemperature, 200 for on-state open load and 1000 for off-state open load.

Faults are ranked in a fixed order. Supply faults come first, then overtemperature, then the open-load conditions. Both outputs of each channel are registered, so they reflect the inputs seen at the previous clock edge.

Top module: `lsw_diag_core`

## Requirements
- R1: While the synchronous reset `rst` is high, every `gate_en` bit is 0 and every `stat_n` bit is 1.
- R2: With no flag set, `gate_en[c]` equals `cmd[c]` of the previous cycle, and `stat_n[c]` is 1. Each channel is unaffected by the other channel's inputs.
- R3: While `ot_flag[c]` is set, `gate_en[c]` is 0. One cycle after the flag clears, the gate follows `cmd[c]` again, with no other action needed.
- R4: If `ot_flag[c]` and `cmd[c]` are both held high, `stat_n[c]` goes to 0 one cycle after `OT_TICKS` ticks have been counted. With `cmd[c]` low, an overtemperature leaves `stat_n[c]` at 1 and blocks the open-load reports of that channel.
- R5: `ilim_flag[c]` has no effect on `gate_en[c]` or `stat_n[c]`.
- R6: While `uv_flag` is set, all gates are 0 and all status lines are 1. This design fixes the status value that would otherwise be don't-care.
- R7: While `ov_flag` is set, all gates are 0 and all status lines are 1.
- R8: If `uc_flag[c]` and `cmd[c]` are both held high, `stat_n[c]` goes to 0 one cycle after `UC_TICKS` ticks. With `cmd[c]` low, the flag has no effect.
- R9: If `cmd[c]` is low and `oh_flag[c]` is set, `stat_n[c]` goes to 0 once `OFF_TICKS` ticks have passed since the last falling edge of `cmd[c]` (or since reset). With `cmd[c]` high, `oh_flag[c]` has no effect.
- R10: If a filtered condition drops before its count completes (overtemperature or undercurrent flag clears, or the command rises), its count restarts from zero.
- R11: The ranking is fixed: supply faults, then overtemperature, then open load. A supply fault masks every status report. An active overtemperature flag decides the status of its channel on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock-enable for the delay counters |
| cmd | input | N_CH | Per-channel on command |
| ot_flag | input | N_CH | Overtemperature flag (hysteresis is applied in the analog comparator) |
| ilim_flag | input | N_CH | Current-limit-active flag |
| uc_flag | input | N_CH | On-state undercurrent flag |
| oh_flag | input | N_CH | Output-high-while-off flag |
| uv_flag | input | 1 | Supply undervoltage, shared |
| ov_flag | input | 1 | Supply overvoltage, shared |
| gate_en | output | N_CH | Power stage enable |
| stat_n | output | N_CH | Active-low diagnostic status |

## Verification
Several rules can act on one channel in the same cycle, for example an overtemperature delay expiring while undercurrent is also counting, or a supply fault rising at the moment a status line would fall. The random phase holds each flag for long stretches with an irregular tick, so the filter counts regularly complete while other flags are active. Directed phases stack overtemperature, undercurrent, output-high and overvoltage on one channel. Every cycle is judged against a ranking model in the bench that applies the fault order from the requirements.

// File: rtl/lsw_diag_core.sv
module lsw_diag_core #(
  parameter int N_CH      = 2,
  parameter int OT_TICKS  = 20,
  parameter int UC_TICKS  = 200,
  parameter int OFF_TICKS = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [N_CH-1:0] cmd,
  input  logic [N_CH-1:0] ot_flag,
  input  logic [N_CH-1:0] ilim_flag,
  input  logic [N_CH-1:0] uc_flag,
  input  logic [N_CH-1:0] oh_flag,
  input  logic            uv_flag,
  input  logic            ov_flag,
  output logic [N_CH-1:0] gate_en,
  output logic [N_CH-1:0] stat_n
);

  localparam int OTW  = $clog2(OT_TICKS + 1);
  localparam int UCW  = $clog2(UC_TICKS + 1);
  localparam int OFFW = $clog2(OFF_TICKS + 1);
  localparam logic [OTW-1:0]  OT_LIM  = OTW'(OT_TICKS);
  localparam logic [UCW-1:0]  UC_LIM  = UCW'(UC_TICKS);
  localparam logic [OFFW-1:0] OFF_LIM = OFFW'(OFF_TICKS);

  wire supply_bad = uv_flag | ov_flag;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [OTW-1:0]  ot_cnt;
    logic [UCW-1:0]  uc_cnt;
    logic [OFFW-1:0] off_cnt;
    logic            en_r, st_r;

    wire ot_done  = (ot_cnt == OT_LIM);
    wire uc_done  = (uc_cnt == UC_LIM);
    wire off_done = (off_cnt == OFF_LIM);

    wire fault = !supply_bad &&
                 (ot_flag[c] ? (cmd[c] && ot_done)
                             : (cmd[c] ? uc_done : (oh_flag[c] && off_done)));

    always_ff @(posedge clk) begin
      if (rst) begin
        ot_cnt  <= '0;
        uc_cnt  <= '0;
        off_cnt <= '0;
        en_r    <= 1'b0;
        st_r    <= 1'b1;
      end else begin
        if (!(ot_flag[c] && cmd[c]))    ot_cnt <= '0;
        else if (tick && !ot_done)      ot_cnt <= ot_cnt + 1'b1;

        if (!(uc_flag[c] && cmd[c]))    uc_cnt <= '0;
        else if (tick && !uc_done)      uc_cnt <= uc_cnt + 1'b1;

        if (cmd[c])                     off_cnt <= '0;
        else if (tick && !off_done)     off_cnt <= off_cnt + 1'b1;

        en_r <= cmd[c] && !supply_bad && !ot_flag[c];
        st_r <= !fault;
      end
    end

    assign gate_en[c] = en_r;
    assign stat_n[c]  = st_r;

    p_ot_gate_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(ot_flag[c])) |-> !gate_en[c]);

    p_cool_restart_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(cmd[c] && !ot_flag[c] && !uv_flag && !ov_flag)) |-> gate_en[c]);

    p_ot_low_cmd_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(ot_flag[c] && !cmd[c])) |-> stat_n[c]);

    p_ilim_keeps_on_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(ilim_flag[c] && cmd[c] && !ot_flag[c] && !uv_flag && !ov_flag))
        |-> gate_en[c]);

    p_uc_ignored_off_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!cmd[c] && !oh_flag[c])) |-> stat_n[c]);

    p_oh_ignored_on_r9: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(cmd[c] && !ot_flag[c] && !uc_flag[c]) && $past(cmd[c], 2)
        && $past(!uc_flag[c], 2)) |-> stat_n[c]);

    p_ot_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
      (ot_cnt != '0) |-> $past(ot_flag[c] && cmd[c]));
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (gate_en == '0 && stat_n == '1));

  p_supply_gate_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(uv_flag || ov_flag)) |-> gate_en == '0);

  p_supply_stat_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(uv_flag || ov_flag)) |-> stat_n == '1);

endmodule

// File: tb/test_lsw_diag_core.sv
module test_lsw_diag_core;
  localparam int N  = 2;
  localparam int OT = 20;
  localparam int UC = 200;
  localparam int OF = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [N-1:0] cmd = '0, ot = '0, il = '0, uc = '0, oh = '0;
  logic uv = 1'b0, ov = 1'b0;
  logic [N-1:0] gate_en, stat_n;

  always #5 clk = ~clk;

  lsw_diag_core #(.N_CH(N), .OT_TICKS(OT), .UC_TICKS(UC), .OFF_TICKS(OF)) i_lsw_diag_core (
    .clk(clk), .rst(rst), .tick(tick), .cmd(cmd), .ot_flag(ot), .ilim_flag(il),
    .uc_flag(uc), .oh_flag(oh), .uv_flag(uv), .ov_flag(ov),
    .gate_en(gate_en), .stat_n(stat_n));

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";
  int m_ot [N], m_uc [N], m_of [N];
  logic [N-1:0] e_gate = '0, e_st = '1;
  logic [N-1:0] s_cmd, s_ot, s_uc, s_oh, s_il;
  logic s_uv, s_ov;

  // Fault ranking taken from the requirements: supply, then overtemperature, then open load
  function automatic logic exp_fault(logic c, logic o, logic u_done, logic h, logic o_done,
                                     logic f_done, logic sup);
    if (sup) return 1'b0;
    if (o) return c & o_done;
    if (c) return u_done;
    return h & f_done;
  endfunction

  function automatic string tag_of(int c);
    if (phase != "") return phase;
    if (s_uv) return "R6";
    if (s_ov) return "R7";
    if (s_ot[c]) return "R3/R4";
    if (s_cmd[c] && s_uc[c]) return "R8";
    if (!s_cmd[c] && s_oh[c]) return "R9";
    if (s_il[c]) return "R5";
    return "R2";
  endfunction

  task automatic chk(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    s_cmd = cmd; s_ot = ot; s_uc = uc; s_oh = oh; s_il = il; s_uv = uv; s_ov = ov;
    if (rst) begin
      e_gate = '0; e_st = '1;
      for (int c = 0; c < N; c++) begin m_ot[c] = 0; m_uc[c] = 0; m_of[c] = 0; end
    end else begin
      for (int c = 0; c < N; c++) begin
        e_gate[c] = cmd[c] & ~uv & ~ov & ~ot[c];
        e_st[c] = ~exp_fault(cmd[c], ot[c], m_uc[c] == UC, oh[c], m_ot[c] == OT,
                             m_of[c] == OF, uv | ov);
        if (!(ot[c] && cmd[c])) m_ot[c] = 0; else if (tick && m_ot[c] < OT) m_ot[c]++;
        if (!(uc[c] && cmd[c])) m_uc[c] = 0; else if (tick && m_uc[c] < UC) m_uc[c]++;
        if (cmd[c]) m_of[c] = 0; else if (tick && m_of[c] < OF) m_of[c]++;
      end
    end
    #2;
    for (int c = 0; c < N; c++) begin
      chk(tag_of(c), $sformatf("gate_en[%0d]", c), gate_en[c], e_gate[c]);
      chk(tag_of(c), $sformatf("stat_n[%0d]", c), stat_n[c], e_st[c]);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(150000);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    phase = "R1";
    cmd = 2'b11; ot = 2'b11; uc = 2'b11;
    run(4);
    rst = 1'b0; cmd = '0; ot = '0; uc = '0;

    phase = "R2";
    for (int i = 0; i < 40; i++) begin @(negedge clk); cmd = 2'($urandom); end

    phase = "R3/R4";
    cmd = 2'b11; ot = 2'b01; run(OT + 5);
    ot = 2'b00; run(5);
    phase = "R4"; cmd = 2'b10; ot = 2'b11; run(OT + 5); ot = 0;

    phase = "R5";
    cmd = 2'b11; il = 2'b11; run(20);
    il = 2'b01; cmd = 2'b01; run(10); il = 0;

    phase = "R6";
    uv = 1'b1; cmd = 2'b11; ot = 2'b01; run(OT + 5);
    uv = 1'b0; ot = 0; run(3);

    phase = "R7";
    ov = 1'b1; cmd = 2'b00; oh = 2'b11; run(OF + 5);
    ov = 1'b0; run(5); oh = 0;

    phase = "R8";
    cmd = 2'b11; uc = 2'b01; run(UC + 5);
    cmd = 2'b00; run(5); uc = 0;

    phase = "R9";
    cmd = 2'b11; oh = 2'b11; run(10);
    cmd = 2'b01; run(OF + 5);
    cmd = 2'b11; run(5); oh = 0;

    phase = "R10";
    cmd = 2'b11; uc = 2'b11; run(UC - 3);
    uc = 2'b10; run(1); uc = 2'b11; run(UC - 3);
    ot = 2'b01; run(OT - 2); ot = 0; run(1); ot = 2'b01; run(OT + 3); ot = 0; uc = 0;

    phase = "R11";
    cmd = 2'b01; ot = 2'b11; uc = 2'b11; oh = 2'b11; run(OF + 5);
    ov = 1'b1; run(5); ov = 1'b0; cmd = 2'b11; run(UC + 5);
    ot = 0; run(3); uc = 0; oh = 0; cmd = 0;

    phase = "";
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 3) != 0);
      for (int c = 0; c < N; c++) begin
        if ($urandom_range(0, 199) == 0) cmd[c] = ~cmd[c];
        if ($urandom_range(0, 299) == 0) ot[c] = ~ot[c];
        if ($urandom_range(0, 99) == 0) il[c] = ~il[c];
        if ($urandom_range(0, 249) == 0) uc[c] = ~uc[c];
        if ($urandom_range(0, 399) == 0) oh[c] = ~oh[c];
      end
      if (!uv && $urandom_range(0, 1999) == 0) uv = 1'b1;
      else if (uv && $urandom_range(0, 49) == 0) uv = 1'b0;
      if (!ov && $urandom_range(0, 1999) == 0) ov = 1'b1;
      else if (ov && $urandom_range(0, 49) == 0) ov = 1'b0;
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule